// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-side register front end of a three-channel interval timer. The host sees an 8-bit data bus and a 2-bit address. Addresses 0 to 2 are the count ports of channels 0 to 2, and address 3 is the control port. Control words set the counting mode, the BCD flag and the byte access mode of each channel. The byte access modes are low byte only, high byte only, or low byte then high byte. The block sequences byte-wide accesses to the 16-bit counts. When a count write completes, it sends a one-cycle load strobe and the count value to the addressed channel.

Reads return either the live count of a channel or a value captured earlier. A single-channel latch command captures a count. A read-back command can capture counts and status bytes for any set of channels at once. A captured status byte is returned before a captured count. Each channel also reports through an input when its pending count has been taken into the counter, and the status byte uses this to show a null-count flag. The counting logic lives in the channels and is outside this block.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset every channel has mode 0, BCD 0, access mode 3 (low then high), no captured count or status, both byte toggles on the first byte, null-count clear and no load strobe.
- R2: A write to address 3 with bits 7:6 = 0..2 and bits 5:4 nonzero sets that channel's access mode from bits 5:4 (1 low only, 2 high only, 3 low then high), its mode from bits 3:1 (6 and 7 are stored as 2 and 3) and its BCD flag from bit 0. The mode and BCD outputs change only on such writes.
- R3: A control word that sets a channel's access mode returns that channel's read toggle and write toggle to the first byte.
- R4: A count write loads {8'h00, byte} in access mode 1 and {byte, 8'h00} in access mode 2. In access mode 3 the first byte is held and the second byte loads {second, first}. A load raises load_o[ch] for one cycle in the cycle after the completing write, with the value on the channel's slice of load_val_o. Writes to address 3 never load.
- R5: An uncaptured read returns the live low byte in access mode 1 and the live high byte in access mode 2. In access mode 3 it alternates low, high, using a read toggle that is independent of the write toggle.
- R6: A control word with bits 5:4 = 0 captures the live count of the channel in bits 7:6. Following reads return the captured low byte (mode 1), high byte (mode 2) or low then high (mode 3). After that, reads return the live count again.
- R7: A write to address 3 with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count and bit 4 = 0 captures the status of every selected channel in the same cycle.
- R8: A count capture or status capture request for a channel that still holds an unread captured value of the same kind is ignored.
- R9: The status byte is {output level, null-count, access mode[1:0], mode[2:0], BCD} from bit 7 down to bit 0, taken when captured. A captured status is read, and then cleared, before any captured count.
- R10: The null-count flag is set when a count load is issued and cleared when cnt_loaded_i of that channel pulses.
- R11: A read at address 3 returns 8'h00, and reads never change mode or BCD settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address: 0..2 count ports, 3 control |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe; read side effects apply at the clock edge |
| rdata_o | output | 8 | Read data for the current address (combinational) |
| load_o | output | 3 | Per-channel one-cycle count load strobe |
| load_val_o | output | 48 | Count value per channel, channel c in bits 16c+15:16c |
| mode_o | output | 9 | Counting mode per channel, channel c in bits 3c+2:3c |
| bcd_o | output | 3 | BCD flag per channel |
| live_cnt_i | input | 48 | Live count per channel, channel c in bits 16c+15:16c |
| out_lvl_i | input | 3 | Output level per channel |
| cnt_loaded_i | input | 3 | Per-channel pulse: pending count taken into the counter |

## Verification
The assertions check every cycle that load strobes are one-hot or idle and that each strobe follows a write to that channel's count port. They also check that control-port writes never cause a load, that mode and BCD hold steady between control writes, and that the BCD bit is taken from the control word. The byte sequencing has to be shown by the bench's scenarios: the independence of the read and write toggles, the reset of both toggles by a control word, and the return to live reads after a captured count. The same holds for dropping a repeated capture, the status-before-count order, the status field layout and the null-count handshake.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 3;
  localparam int DATA_W = 8;
  localparam int MODE_W = 3;
  localparam int AW     = 2;

  // access field; ACC_NONE doubles as "nothing captured"
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;
endpackage

// File: rtl/tmr_ctl_dec.sv
module tmr_ctl_dec
  import tmr_pkg::*;
#(
  parameter int N_CH  = NCH,
  parameter int DW    = DATA_W
) (
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_CH-1:0]   cfg_we_o,
  output logic [N_CH-1:0]   cnt_lat_o,
  output logic [N_CH-1:0]   st_lat_o,
  output acc_e              cfg_acc_o,
  output logic [MODE_W-1:0] cfg_mode_o,
  output logic              cfg_bcd_o
);
  logic [1:0]        sel;
  logic [MODE_W-1:0] raw_mode;
  logic              is_ctl;

  always_comb begin
    sel        = wdata_i[7:6];
    raw_mode   = wdata_i[3:1];
    is_ctl     = wr_i && (addr_i == 2'd3);
    cfg_acc_o  = acc_e'(wdata_i[5:4]);
    cfg_bcd_o  = wdata_i[0];
    // modes 6/7 alias 2/3
    cfg_mode_o = (raw_mode[2] && raw_mode[1]) ? {1'b0, raw_mode[1:0]} : raw_mode;
    cfg_we_o   = '0;
    cnt_lat_o  = '0;
    st_lat_o   = '0;
    if (is_ctl) begin
      for (int c = 0; c < N_CH; c++) begin
        if (sel == 2'd3) begin
          if (wdata_i[c+1]) begin
            cnt_lat_o[c] = !wdata_i[5];
            st_lat_o[c]  = !wdata_i[4];
          end
        end else if (sel == 2'(c)) begin
          if (wdata_i[5:4] == 2'd0) cnt_lat_o[c] = 1'b1;
          else                      cfg_we_o[c]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int  DW    = DATA_W,
  localparam int CW    = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  acc_e              cfg_acc_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_bcd_i,
  input  logic              cnt_lat_i,
  input  logic              st_lat_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_en_i,
  input  logic [CW-1:0]     live_cnt_i,
  input  logic              out_lvl_i,
  input  logic              cnt_loaded_i,
  output logic              load_o,
  output logic [CW-1:0]     load_val_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o,
  output logic [DW-1:0]     rdata_o
);
  acc_e          acc_q, lat_q;
  logic          wr_hi_q, rd_hi_q, null_q, st_vld_q;
  logic [DW-1:0] lo_hold_q, st_q;
  logic [CW-1:0] lat_cnt_q;
  logic          ld_now;
  logic [CW-1:0] ld_val;

  always_comb begin
    ld_now = 1'b0;
    ld_val = '0;
    if (wr_en_i) begin
      unique case (acc_q)
        ACC_LO:   begin ld_now = 1'b1; ld_val = {{DW{1'b0}}, wdata_i}; end
        ACC_HI:   begin ld_now = 1'b1; ld_val = {wdata_i, {DW{1'b0}}}; end
        ACC_WORD: begin ld_now = wr_hi_q; ld_val = {wdata_i, lo_hold_q}; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_WORD;
      mode_o     <= '0;
      bcd_o      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      lo_hold_q  <= '0;
      null_q     <= 1'b0;
      lat_q      <= ACC_NONE;
      lat_cnt_q  <= '0;
      st_vld_q   <= 1'b0;
      st_q       <= '0;
      load_o     <= 1'b0;
      load_val_o <= '0;
    end else begin
      load_o <= ld_now;
      if (ld_now) load_val_o <= ld_val;

      if (wr_en_i && acc_q == ACC_WORD) begin
        wr_hi_q <= !wr_hi_q;
        if (!wr_hi_q) lo_hold_q <= wdata_i;
      end

      if (ld_now)            null_q <= 1'b1;
      else if (cnt_loaded_i) null_q <= 1'b0;

      if (rd_en_i) begin
        if (st_vld_q)              st_vld_q <= 1'b0;
        else if (lat_q != ACC_NONE) lat_q   <= (lat_q == ACC_WORD) ? ACC_HI : ACC_NONE;
        else if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
      end

      if (cfg_we_i) begin
        acc_q   <= cfg_acc_i;
        mode_o  <= cfg_mode_i;
        bcd_o   <= cfg_bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end

      if (cnt_lat_i && lat_q == ACC_NONE) begin
        lat_q     <= acc_q;
        lat_cnt_q <= live_cnt_i;
      end

      if (st_lat_i && !st_vld_q) begin
        st_vld_q <= 1'b1;
        st_q     <= DW'({out_lvl_i, null_q, acc_q, mode_o, bcd_o});
      end
    end
  end

  always_comb begin
    if (st_vld_q)
      rdata_o = st_q;
    else if (lat_q != ACC_NONE)
      rdata_o = (lat_q == ACC_HI) ? lat_cnt_q[CW-1:DW] : lat_cnt_q[DW-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
      rdata_o = live_cnt_i[CW-1:DW];
    else
      rdata_o = live_cnt_i[DW-1:0];
  end
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_pkg::*;
#(
  parameter int  DW = DATA_W,
  localparam int CW = 2 * DW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [DW-1:0]         rdata_o,
  output logic [NCH-1:0]        load_o,
  output logic [NCH*CW-1:0]     load_val_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH-1:0]        bcd_o,
  input  logic [NCH*CW-1:0]     live_cnt_i,
  input  logic [NCH-1:0]        out_lvl_i,
  input  logic [NCH-1:0]        cnt_loaded_i
);
  logic [NCH-1:0]    cfg_we, cnt_lat, st_lat;
  acc_e              cfg_acc;
  logic [MODE_W-1:0] cfg_mode;
  logic              cfg_bcd;
  logic [DW-1:0]     ch_rd [NCH];

  tmr_ctl_dec #(.N_CH(NCH), .DW(DW)) u_dec (
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cfg_we_o  (cfg_we),
    .cnt_lat_o (cnt_lat),
    .st_lat_o  (st_lat),
    .cfg_acc_o (cfg_acc),
    .cfg_mode_o(cfg_mode),
    .cfg_bcd_o (cfg_bcd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_chan_regs #(.DW(DW)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we[c]),
      .cfg_acc_i   (cfg_acc),
      .cfg_mode_i  (cfg_mode),
      .cfg_bcd_i   (cfg_bcd),
      .cnt_lat_i   (cnt_lat[c]),
      .st_lat_i    (st_lat[c]),
      .wr_en_i     (wr_i && addr_i == AW'(c)),
      .wdata_i     (wdata_i),
      .rd_en_i     (rd_i && addr_i == AW'(c)),
      .live_cnt_i  (live_cnt_i[c*CW +: CW]),
      .out_lvl_i   (out_lvl_i[c]),
      .cnt_loaded_i(cnt_loaded_i[c]),
      .load_o      (load_o[c]),
      .load_val_o  (load_val_o[c*CW +: CW]),
      .mode_o      (mode_o[c*MODE_W +: MODE_W]),
      .bcd_o       (bcd_o[c]),
      .rdata_o     (ch_rd[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (addr_i == AW'(c)) rdata_o = ch_rd[c];
  end
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk
  import tmr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [AW-1:0]         addr_i,
  input logic [DW-1:0]         wdata_i,
  input logic                  wr_i,
  input logic [NCH-1:0]        load_o,
  input logic [NCH*MODE_W-1:0] mode_o,
  input logic [NCH-1:0]        bcd_o
);
  assert_load_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  assert_ctl_no_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3) |=> (load_o == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ld
    assert_load_after_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[c] |-> $past(wr_i && addr_i == AW'(c)));
  end

  assert_cfg_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 2'd3) |=> ($stable(mode_o) && $stable(bcd_o)));

  assert_bcd_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'd0 && wdata_i[5:4] != 2'd0)
      |=> (bcd_o[0] == $past(wdata_i[0])));
endmodule

bind tmr_bus_if tmr_bus_if_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .wr_i   (wr_i),
  .load_o (load_o),
  .mode_o (mode_o),
  .bcd_o  (bcd_o)
);

// File: tb/tmr_bus_if_bench.sv
module tmr_bus_if_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [2:0]  load_o;
  logic [47:0] load_val_o;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;
  logic [47:0] live_cnt_i = '0;
  logic [2:0]  out_lvl_i = '0;
  logic [2:0]  cnt_loaded_i = '0;

  always #4 clk_i = ~clk_i;

  tmr_bus_if u_tmr_bus_if (.*);

  int n_chk = 0, n_err = 0;
  logic [7:0]  rd_exp_q[$];
  string       rd_tag_q[$];
  logic [1:0]  ld_ch_q[$];
  logic [15:0] ld_val_q[$];
  string       ld_tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic exp_load(input logic [1:0] c, input logic [15:0] v, input string tag);
    ld_ch_q.push_back(c); ld_val_q.push_back(v); ld_tag_q.push_back(tag);
  endtask

  // monitor: compares results against scoreboard queues
  initial forever begin
    @(negedge clk_i); #2;
    if (rd_i) begin
      if (rd_exp_q.size() == 0) chk(0, "R5 unexpected read", 16'(rdata_o), 16'h0);
      else begin
        automatic logic [7:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        chk(rdata_o == e, t, 16'(rdata_o), 16'(e));
      end
    end
    if (|load_o) begin
      if (ld_ch_q.size() == 0) chk(0, "R4 unexpected load", 16'(load_o), 16'h0);
      else begin
        automatic logic [1:0]  ec = ld_ch_q.pop_front();
        automatic logic [15:0] ev = ld_val_q.pop_front();
        automatic string t = ld_tag_q.pop_front();
        chk(load_o == (3'b001 << ec), {t, " channel"}, 16'(load_o), 16'(3'b001 << ec));
        chk(load_val_o[ec*16 +: 16] == ev, {t, " value"}, load_val_o[ec*16 +: 16], ev);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    live_cnt_i = {16'hE5F6, 16'hC3D4, 16'hA1B2};
    out_lvl_i  = 3'b010;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(mode_o == 9'd0, "R1 mode", 16'(mode_o), 16'h0);
    chk(bcd_o == 3'd0, "R1 bcd", 16'(bcd_o), 16'h0);
    chk(load_o == 3'd0, "R1 load", 16'(load_o), 16'h0);
    rd(0, 8'hB2, "R1 reset word access low");
    rd(0, 8'hA1, "R1 reset word access high");
    wr(3, 8'hE4);                       // R7 status only, ch1
    rd(1, 8'hB0, "R9 reset status ch1");
    rd(1, 8'hD4, "R9 live after status low");
    rd(1, 8'hC3, "R9 live after status high");

    // R2/R4/R5 low-only on ch0
    wr(3, 8'h15);
    chk(mode_o[2:0] == 3'd2, "R2 mode ch0", 16'(mode_o[2:0]), 16'd2);
    chk(bcd_o[0] == 1'b1, "R2 bcd ch0", 16'(bcd_o[0]), 16'd1);
    exp_load(0, 16'h0034, "R4 low-only load");
    wr(0, 8'h34);
    rd(0, 8'hB2, "R5 low-only read 1");
    rd(0, 8'hB2, "R5 low-only read 2");

    // high-only on ch1
    wr(3, 8'h66);
    chk(mode_o[5:3] == 3'd3, "R2 mode ch1", 16'(mode_o[5:3]), 16'd3);
    exp_load(1, 16'h1200, "R4 high-only load");
    wr(1, 8'h12);
    rd(1, 8'hC3, "R5 high-only read 1");
    rd(1, 8'hC3, "R5 high-only read 2");

    // word access on ch2, mode 6 aliases 2
    wr(3, 8'hBC);
    chk(mode_o[8:6] == 3'd2, "R2 mode alias ch2", 16'(mode_o[8:6]), 16'd2);
    wr(2, 8'h78);
    exp_load(2, 16'h5678, "R4 word load");
    wr(2, 8'h56);
    wr(2, 8'h11);
    rd(2, 8'hF6, "R5 word read low between writes");
    rd(2, 8'hE5, "R5 word read high between writes");
    exp_load(2, 16'h2211, "R4 word load interleaved");
    wr(2, 8'h22);

    // R3 control word resets toggles
    wr(2, 8'h99);
    rd(2, 8'hF6, "R3 pre low");
    wr(3, 8'hBC);
    exp_load(2, 16'h0201, "R3 write toggle reset");
    wr(2, 8'h01);
    wr(2, 8'h02);
    rd(2, 8'hF6, "R3 read toggle reset");

    // R6 latch command on ch2 (read toggle now high)
    wr(3, 8'h80);
    live_cnt_i[32 +: 16] = 16'h1357;
    rd(2, 8'hF6, "R6 latched low");
    rd(2, 8'hE5, "R6 latched high");
    rd(2, 8'h13, "R6 live after latch high");
    rd(2, 8'h57, "R6 live after latch low");

    // R8 repeat count latch ignored
    wr(3, 8'h80);
    live_cnt_i[32 +: 16] = 16'h2468;
    wr(3, 8'h80);
    rd(2, 8'h57, "R8 first latch low kept");
    rd(2, 8'h13, "R8 first latch high kept");
    rd(2, 8'h24, "R8 live high");

    // R7 read-back: count and status on all channels
    wr(3, 8'hCE);
    live_cnt_i = 48'hFFFF_FFFF_FFFF;
    rd(0, 8'h55, "R7 status ch0");
    rd(0, 8'hB2, "R9 count after status ch0");
    rd(0, 8'hFF, "R7 live ch0");
    rd(1, 8'hE6, "R7 status ch1");
    rd(1, 8'hC3, "R7 count ch1 high-only");
    rd(1, 8'hFF, "R7 live ch1");
    rd(2, 8'h74, "R7 status ch2");
    rd(2, 8'h68, "R7 count ch2 low");
    rd(2, 8'h24, "R7 count ch2 high");
    rd(2, 8'hFF, "R7 live ch2");

    // R8 repeat status latch ignored
    wr(3, 8'hE2);
    out_lvl_i[0] = 1'b1;
    wr(3, 8'hE2);
    rd(0, 8'h55, "R8 first status kept");
    rd(0, 8'hFF, "R8 status consumed once");

    // R10 null-count handshake
    @(negedge clk_i); cnt_loaded_i[0] = 1'b1;
    @(negedge clk_i); cnt_loaded_i[0] = 1'b0;
    wr(3, 8'hE2);
    rd(0, 8'h95, "R10 null cleared");
    exp_load(0, 16'h0077, "R10 load");
    wr(0, 8'h77);
    wr(3, 8'hE2);
    rd(0, 8'hD5, "R10 null set by load");

    // R7 selective count-only read-back on ch1
    live_cnt_i[16 +: 16] = 16'hABCD;
    wr(3, 8'hD4);
    live_cnt_i[16 +: 16] = 16'h0000;
    rd(1, 8'hAB, "R7 selective latch ch1");
    rd(1, 8'h00, "R7 selective live ch1");
    rd(0, 8'hFF, "R7 unselected ch0 live");

    // R11 control port read, settings untouched
    rd(3, 8'h00, "R11 control read zero");
    chk(mode_o == {3'd2, 3'd3, 3'd2}, "R11 modes kept", 16'(mode_o), 16'({3'd2, 3'd3, 3'd2}));
    chk(bcd_o == 3'b001, "R11 bcd kept", 16'(bcd_o), 16'h1);

    repeat (3) @(negedge clk_i);
    chk(rd_exp_q.size() == 0, "R5 reads drained", 16'(rd_exp_q.size()), 16'h0);
    chk(ld_ch_q.size() == 0, "R4 loads drained", 16'(ld_ch_q.size()), 16'h0);
    finish_run();
  end
endmodule